// File: doc/BRIEF.md
# Fault Rollback Register Checkpoint

This block keeps a small set of processor state and can undo changes to that state when an instruction faults. The state is a bank of segment registers, a stack pointer, a flags register, a current privilege level and a task register. Each segment register holds a selector and its cached descriptor as one word. Each register has its own write port and a live value on a read port. The segment bank is read through one combinational read port that is selected by index.

Each register has a backup copy and a dirty mark. The first write after a commit point copies the old live value into the backup and sets the mark. Later writes change only the live value. The instruction commit strobe marks a commit point: at each new instruction, and at each repeat iteration of a string instruction. It drops every backup without touching the live values. The fault strobe copies each dirty backup into its live register and clears all marks.

When a single-step trap is pending, the commit is taken after execution, so a write in the same cycle becomes part of the committed state. The task register is checkpointed only by its own task-switch commit strobe. It ignores the instruction commit.

Top module: `state_rollback`

## Requirements
- R1: After reset, `seg_dirty` is all zero. Every segment reads zero, `sp_q` equals SP_RST (0), `fl_q` equals FL_RST (32'h2), `cpl_q` equals CPL_RST (0) and `tr_q` is zero.
- R2: A write to a register shows on its read port on the cycle after the write edge. `seg_rdata` shows segment `seg_ridx` combinationally, as {selector, descriptor} with the selector in the upper SEL_W bits.
- R3: The first write to segment i after a commit point sets bit i of `seg_dirty`.
- R4: After two or more writes to one register since the last commit, a fault returns the value the register held before the first of those writes.
- R5: A commit with `step_trap` low and no write clears every `seg_dirty` bit and keeps all live values, so a later fault changes nothing. With a commit at each repeat iteration, a fault undoes only the last iteration.
- R6: A fault restores every dirty segment, the stack pointer, the flags and the privilege level in the next cycle, and clears `seg_dirty`. Clean registers keep their values.
- R7: When a write and a fault arrive in the same cycle, the fault wins and the write is dropped.
- R8: When a write and a commit arrive in the same cycle with `step_trap` low, the new value is written and the dirty bit is set. A later fault restores the value from before that write.
- R9: A commit with `step_trap` high commits any write in the same cycle. The dirty bits clear, and a later fault keeps the written value.
- R10: The task register is committed only by `tsw_commit`. A task register write in the same cycle as `tsw_commit` is committed. An instruction `commit` leaves its backup in place for a later fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_we | input | 1 | Segment write strobe |
| seg_widx | input | IDX_W | Segment index to write |
| seg_wdata | input | SEL_W+DESC_W | New selector and descriptor |
| seg_ridx | input | IDX_W | Segment index to read |
| seg_rdata | output | SEL_W+DESC_W | Live selector and descriptor of `seg_ridx` |
| seg_dirty | output | NSEG | Per-segment backup-valid bits |
| sp_we | input | 1 | Stack pointer write strobe |
| sp_wdata | input | SP_W | New stack pointer |
| sp_q | output | SP_W | Live stack pointer |
| fl_we | input | 1 | Flags write strobe |
| fl_wdata | input | FL_W | New flags |
| fl_q | output | FL_W | Live flags |
| cpl_we | input | 1 | Privilege level write strobe |
| cpl_wdata | input | CPL_W | New privilege level |
| cpl_q | output | CPL_W | Live privilege level |
| tr_we | input | 1 | Task register write strobe |
| tr_wdata | input | SEL_W+DESC_W | New task selector and descriptor |
| tr_q | output | SEL_W+DESC_W | Live task register |
| commit | input | 1 | Instruction or iteration commit point |
| step_trap | input | 1 | Single-step trap pending; commit takes post-execution state |
| tsw_commit | input | 1 | Task-switch commit for the task register |
| fault | input | 1 | Fault: roll back dirty registers |

## Verification
The hardest cases are the strobe collisions: a write landing in the same cycle as a fault, as an ordinary commit, or as a post-execution commit. A sequential bench naturally keeps these apart. Each scenario task therefore raises both strobes before a single edge. It then fires a fault afterwards, so the saved backup becomes visible on the read ports. The task register's separate commit is reached the same way: an instruction commit comes between its write and the fault.

// File: rtl/rb_pkg.sv
`timescale 1ns/1ps
package rb_pkg;
   typedef enum logic [2:0] {
      RB_HOLD,
      RB_WRITE,
      RB_COMMIT,
      RB_COMMIT_WR,
      RB_COMMIT_POST,
      RB_RESTORE
   } rb_act_e;

   // Priority: fault, post-execution commit, commit, write.
   function automatic rb_act_e rb_pick(input logic we, input logic cmt,
                                       input logic post, input logic flt);
      if (flt)              return RB_RESTORE;
      else if (cmt && post) return RB_COMMIT_POST;
      else if (cmt && we)   return RB_COMMIT_WR;
      else if (cmt)         return RB_COMMIT;
      else if (we)          return RB_WRITE;
      else                  return RB_HOLD;
   endfunction
endpackage

// File: rtl/rb_cell.sv
`timescale 1ns/1ps
module rb_cell #(
   parameter int          W   = 8,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   input  logic         cmt,
   input  logic         post,
   input  logic         flt,
   output logic [W-1:0] q,
   output logic         dirty
);
   import rb_pkg::*;

   if (W < 1) begin : g_bad_width
      $error("rb_cell: W must be at least 1");
   end

   logic [W-1:0] live, shadow;
   logic         dty;
   rb_act_e      act;

   assign act = rb_pick(we, cmt, post, flt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live   <= RST;
         shadow <= RST;
         dty    <= 1'b0;
      end else begin
         unique case (act)
            RB_RESTORE: begin
               if (dty) live <= shadow;
               dty <= 1'b0;
            end
            RB_COMMIT_POST: begin
               if (we) live <= wdata;
               dty <= 1'b0;
            end
            RB_COMMIT_WR: begin
               shadow <= live;
               live   <= wdata;
               dty    <= 1'b1;
            end
            RB_COMMIT: dty <= 1'b0;
            RB_WRITE: begin
               if (!dty) shadow <= live;
               live <= wdata;
               dty  <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign q     = live;
   assign dirty = dty;

   // R3: a plain write takes effect and leaves a valid backup
   assert_first_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !flt && !cmt) |=> (dty && q == $past(wdata)));
   // R4: later writes leave the backup untouched
   assert_backup_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dty && !flt && !cmt) |=> (shadow == $past(shadow)));
   // R5: a bare commit discards the backup and keeps the live value
   assert_commit_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt && !post && !we && !flt) |=> (!dty && q == $past(q)));
   // R7: a fault on a clean register drops the same-cycle write
   assert_fault_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flt && !dty) |=> (q == $past(q)));
endmodule

// File: rtl/rb_seg_bank.sv
`timescale 1ns/1ps
module rb_seg_bank #(
   parameter int NSEG  = 8,
   parameter int SEGW  = 80,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [SEGW-1:0]  wdata,
   input  logic [IDX_W-1:0] ridx,
   output logic [SEGW-1:0]  rdata,
   output logic [NSEG-1:0]  dirty,
   input  logic             cmt,
   input  logic             post,
   input  logic             flt
);
   if ((1 << IDX_W) < NSEG) begin : g_bad_idx
      $error("rb_seg_bank: IDX_W too narrow for NSEG");
   end

   logic [SEGW-1:0] seg_q [NSEG];

   for (genvar i = 0; i < NSEG; i++) begin : g_seg
      rb_cell #(.W(SEGW), .RST('0)) u_cell (
         .clk  (clk),
         .rst_n(rst_n),
         .we   (we && (widx == IDX_W'(i))),
         .wdata(wdata),
         .cmt  (cmt),
         .post (post),
         .flt  (flt),
         .q    (seg_q[i]),
         .dirty(dirty[i])
      );
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NSEG; i++)
         if (ridx == IDX_W'(i)) rdata = seg_q[i];
   end

   // R5: a commit with no write leaves no backup marked in the bank
   assert_bank_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt && !we && !flt) |=> (dirty == '0));
   // R3: a write marks at most one more segment
   assert_one_new_dirty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !flt && !cmt) |=> ($countones(dirty & ~$past(dirty)) <= 1));
endmodule

// File: rtl/state_rollback.sv
`timescale 1ns/1ps
module state_rollback #(
   parameter int            NSEG    = 8,
   parameter int            SEL_W   = 16,
   parameter int            DESC_W  = 64,
   parameter int            SP_W    = 32,
   parameter int            FL_W    = 32,
   parameter int            CPL_W   = 2,
   parameter bit            TR_EN   = 1'b1,
   parameter logic [SP_W-1:0]  SP_RST  = '0,
   parameter logic [FL_W-1:0]  FL_RST  = FL_W'(2),
   parameter logic [CPL_W-1:0] CPL_RST = '0,
   localparam int SEGW  = SEL_W + DESC_W,
   localparam int IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seg_we,
   input  logic [IDX_W-1:0] seg_widx,
   input  logic [SEGW-1:0]  seg_wdata,
   input  logic [IDX_W-1:0] seg_ridx,
   output logic [SEGW-1:0]  seg_rdata,
   output logic [NSEG-1:0]  seg_dirty,
   input  logic             sp_we,
   input  logic [SP_W-1:0]  sp_wdata,
   output logic [SP_W-1:0]  sp_q,
   input  logic             fl_we,
   input  logic [FL_W-1:0]  fl_wdata,
   output logic [FL_W-1:0]  fl_q,
   input  logic             cpl_we,
   input  logic [CPL_W-1:0] cpl_wdata,
   output logic [CPL_W-1:0] cpl_q,
   input  logic             tr_we,
   input  logic [SEGW-1:0]  tr_wdata,
   output logic [SEGW-1:0]  tr_q,
   input  logic             commit,
   input  logic             step_trap,
   input  logic             tsw_commit,
   input  logic             fault
);
   if (NSEG < 2 || NSEG > 8) begin : g_bad_nseg
      $error("state_rollback: NSEG must lie in 2..8");
   end
   if (SEL_W < 1 || DESC_W < 1 || SP_W < 1 || FL_W < 1 || CPL_W < 1) begin : g_bad_w
      $error("state_rollback: all widths must be positive");
   end

   logic sp_dty, fl_dty, cpl_dty;

   rb_seg_bank #(.NSEG(NSEG), .SEGW(SEGW), .IDX_W(IDX_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(seg_we), .widx(seg_widx), .wdata(seg_wdata),
      .ridx(seg_ridx), .rdata(seg_rdata), .dirty(seg_dirty),
      .cmt(commit), .post(step_trap), .flt(fault)
   );

   rb_cell #(.W(SP_W), .RST(SP_RST)) u_sp (
      .clk(clk), .rst_n(rst_n), .we(sp_we), .wdata(sp_wdata), .cmt(commit),
      .post(step_trap), .flt(fault), .q(sp_q), .dirty(sp_dty)
   );

   rb_cell #(.W(FL_W), .RST(FL_RST)) u_fl (
      .clk(clk), .rst_n(rst_n), .we(fl_we), .wdata(fl_wdata), .cmt(commit),
      .post(step_trap), .flt(fault), .q(fl_q), .dirty(fl_dty)
   );

   rb_cell #(.W(CPL_W), .RST(CPL_RST)) u_cpl (
      .clk(clk), .rst_n(rst_n), .we(cpl_we), .wdata(cpl_wdata), .cmt(commit),
      .post(step_trap), .flt(fault), .q(cpl_q), .dirty(cpl_dty)
   );

   if (TR_EN) begin : g_tr
      logic tr_dty;
      // The task-switch commit is a post-commit checkpoint: the new task register is kept.
      rb_cell #(.W(SEGW), .RST('0)) u_tr (
         .clk(clk), .rst_n(rst_n), .we(tr_we), .wdata(tr_wdata), .cmt(tsw_commit),
         .post(1'b1), .flt(fault), .q(tr_q), .dirty(tr_dty)
      );
      // R10: an instruction commit keeps the task register backup
      assert_tr_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (tr_dty && commit && !tsw_commit && !fault) |=> tr_dty);
   end else begin : g_no_tr
      assign tr_q = '0;
   end

   // R6: a fault leaves no backup marked anywhere
   assert_fault_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> (seg_dirty == '0 && !sp_dty && !fl_dty && !cpl_dty));
   // R9: a post-execution commit leaves no backup marked
   assert_post_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && step_trap && !fault) |=> (seg_dirty == '0 && !sp_dty && !fl_dty && !cpl_dty));
endmodule

// File: tb/sim_state_rollback.sv
`timescale 1ns/1ps
module sim_state_rollback;
   localparam int SEGW = 80;
   localparam int IDX_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic seg_we = 0;
   logic [IDX_W-1:0] seg_widx = '0, seg_ridx = '0;
   logic [SEGW-1:0] seg_wdata = '0, seg_rdata;
   logic [7:0] seg_dirty;
   logic sp_we = 0, fl_we = 0, cpl_we = 0, tr_we = 0;
   logic [31:0] sp_wdata = '0, sp_q, fl_wdata = '0, fl_q;
   logic [1:0] cpl_wdata = '0, cpl_q;
   logic [SEGW-1:0] tr_wdata = '0, tr_q;
   logic commit = 0, step_trap = 0, tsw_commit = 0, fault = 0;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   state_rollback u0 (
      .clk(clk), .rst_n(rst_n),
      .seg_we(seg_we), .seg_widx(seg_widx), .seg_wdata(seg_wdata),
      .seg_ridx(seg_ridx), .seg_rdata(seg_rdata), .seg_dirty(seg_dirty),
      .sp_we(sp_we), .sp_wdata(sp_wdata), .sp_q(sp_q),
      .fl_we(fl_we), .fl_wdata(fl_wdata), .fl_q(fl_q),
      .cpl_we(cpl_we), .cpl_wdata(cpl_wdata), .cpl_q(cpl_q),
      .tr_we(tr_we), .tr_wdata(tr_wdata), .tr_q(tr_q),
      .commit(commit), .step_trap(step_trap), .tsw_commit(tsw_commit), .fault(fault)
   );

   localparam logic [SEGW-1:0] VA = {16'h0010, 64'hA0A0_0000_0000_00A1};
   localparam logic [SEGW-1:0] VB = {16'h0020, 64'hB0B0_0000_0000_00B1};
   localparam logic [SEGW-1:0] VC = {16'h0030, 64'hC0C0_0000_0000_00C1};
   localparam logic [SEGW-1:0] VD = {16'h0040, 64'hD0D0_0000_0000_00D1};
   localparam logic [SEGW-1:0] VE = {16'h0050, 64'hE0E0_0000_0000_00E1};
   localparam logic [SEGW-1:0] VF = {16'h0060, 64'hF0F0_0000_0000_00F1};

   task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      seg_we = 0; sp_we = 0; fl_we = 0; cpl_we = 0; tr_we = 0;
      commit = 0; step_trap = 0; tsw_commit = 0; fault = 0;
   endtask

   task automatic rd_seg(int idx, output logic [SEGW-1:0] v);
      seg_ridx = IDX_W'(idx);
      #1;
      v = seg_rdata;
   endtask

   task automatic seg_wr(int idx, logic [SEGW-1:0] v);
      seg_we = 1; seg_widx = IDX_W'(idx); seg_wdata = v;
      tick();
   endtask

   task automatic sp_wr(logic [31:0] v);
      sp_we = 1; sp_wdata = v;
      tick();
   endtask

   task automatic do_commit();
      commit = 1;
      tick();
   endtask

   task automatic do_fault();
      fault = 1;
      tick();
   endtask

   task automatic t_reset();
      logic [SEGW-1:0] v;
      chk("R1 dirty", seg_dirty, 0);
      for (int i = 0; i < 8; i++) begin
         rd_seg(i, v);
         chk("R1 seg", v, 0);
      end
      chk("R1 sp", sp_q, 0);
      chk("R1 flags", fl_q, 32'h2);
      chk("R1 cpl", cpl_q, 0);
      chk("R1 tr", tr_q, 0);
   endtask

   task automatic t_write();
      logic [SEGW-1:0] v;
      seg_wr(3, VA);
      rd_seg(3, v);
      chk("R2 seg3", v, VA);
      chk("R3 dirty", seg_dirty, 8'h08);
      sp_wr(32'h100);
      chk("R2 sp", sp_q, 32'h100);
      do_commit();
   endtask

   task automatic t_double();
      logic [SEGW-1:0] v;
      seg_wr(3, VB);
      seg_wr(3, VC);
      rd_seg(3, v);
      chk("R4 live", v, VC);
      chk("R4 dirty", seg_dirty, 8'h08);
      do_fault();
      rd_seg(3, v);
      chk("R4 restored", v, VA);
      chk("R4 clean", seg_dirty, 0);
   endtask

   task automatic t_commit();
      logic [SEGW-1:0] v;
      seg_wr(5, VD);
      do_commit();
      chk("R5 dirty", seg_dirty, 0);
      do_fault();
      rd_seg(5, v);
      chk("R5 kept", v, VD);
      // repeat iterations, each committed before the next
      sp_wr(32'd10); do_commit();
      sp_wr(32'd20); do_commit();
      sp_wr(32'd30);
      do_fault();
      chk("R5 last iteration", sp_q, 32'd20);
   endtask

   task automatic t_multi();
      logic [SEGW-1:0] v;
      do_commit();
      seg_wr(0, VE);
      seg_wr(7, VF);
      sp_wr(32'h1234);
      fl_we = 1; fl_wdata = 32'h246; tick();
      cpl_we = 1; cpl_wdata = 2'd3; tick();
      chk("R6 dirty set", seg_dirty, 8'h81);
      chk("R6 cpl live", cpl_q, 3);
      do_fault();
      rd_seg(0, v); chk("R6 seg0", v, 0);
      rd_seg(7, v); chk("R6 seg7", v, 0);
      rd_seg(3, v); chk("R6 seg3 clean", v, VA);
      rd_seg(5, v); chk("R6 seg5 clean", v, VD);
      chk("R6 sp", sp_q, 32'd20);
      chk("R6 flags", fl_q, 32'h2);
      chk("R6 cpl", cpl_q, 0);
      chk("R6 dirty clear", seg_dirty, 0);
   endtask

   task automatic t_fault_write();
      logic [SEGW-1:0] v;
      seg_we = 1; seg_widx = 3'd2; seg_wdata = VB; fault = 1;
      tick();
      rd_seg(2, v);
      chk("R7 seg2 dropped", v, 0);
      chk("R7 dirty", seg_dirty, 0);
      sp_wr(32'h55);
      sp_we = 1; sp_wdata = 32'h77; fault = 1;
      tick();
      chk("R7 sp restored", sp_q, 32'd20);
   endtask

   task automatic t_commit_write();
      logic [SEGW-1:0] v;
      seg_wr(1, VC);
      do_commit();
      seg_we = 1; seg_widx = 3'd1; seg_wdata = VE; commit = 1;
      tick();
      rd_seg(1, v);
      chk("R8 live", v, VE);
      chk("R8 dirty", seg_dirty, 8'h02);
      do_fault();
      rd_seg(1, v);
      chk("R8 restored", v, VC);
   endtask

   task automatic t_step();
      logic [SEGW-1:0] v;
      seg_wr(6, VF);
      chk("R9 pre dirty", seg_dirty, 8'h40);
      seg_we = 1; seg_widx = 3'd4; seg_wdata = VD; commit = 1; step_trap = 1;
      tick();
      rd_seg(4, v);
      chk("R9 live", v, VD);
      chk("R9 dirty", seg_dirty, 0);
      do_fault();
      rd_seg(4, v); chk("R9 seg4 kept", v, VD);
      rd_seg(6, v); chk("R9 seg6 kept", v, VF);
   endtask

   task automatic t_tr();
      tr_we = 1; tr_wdata = VA; tick();
      chk("R10 tr live", tr_q, VA);
      do_commit();
      do_fault();
      chk("R10 tr rolled back", tr_q, 0);
      tr_we = 1; tr_wdata = VB; tsw_commit = 1; tick();
      chk("R10 tr switch", tr_q, VB);
      do_fault();
      chk("R10 tr kept", tr_q, VB);
      tr_we = 1; tr_wdata = VC; tick();
      do_commit();
      do_fault();
      chk("R10 tr after instr commit", tr_q, VB);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(20 * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1;
      t_reset();
      t_write();
      t_double();
      t_commit();
      t_multi();
      t_fault_write();
      t_commit_write();
      t_step();
      t_tr();
      repeat (2) @(posedge clk);
      summary();
   end
endmodule